// File: doc/BRIEF.md
# Privileged System Control Register File

This block holds the system control words of a processor core and serves them over a coprocessor register-transfer port. Each access carries a primary register number, a secondary selector, two opcode fields, a read or write strobe, a 32-bit data word and the core's privilege state. In the same cycle the block either accepts the access or raises an undefined-instruction response. Each register has its own table of legal (opcode_2, selector) combinations.

Accepted reads return the selected word combinationally in the same cycle. Accepted writes take effect at the next clock edge. Each write is filtered through a per-register mask, and the control word also gets a fixed set of forced-one bits. A nonzero opcode_2 selects an alternate bank. That bank holds the cache-type word and an auxiliary control word. Register 14 holds five debug and breakpoint words, and the selector picks one of them. When a control write flips the byte-order bit, a one-cycle pulse goes out on its own output.

Top module: `sysctl_regfile`

## Requirements
- R1: An access made while `userMode` is 1 is rejected: `undefResp`=1, `accept`=0.
- R2: An access with a nonzero `op1` is rejected.
- R3: Registers 4, 11 and 12 always reject. Registers 0 and 1 need selector 0 and accept any `op2`. Registers 2, 3, 5, 6 and 13 need selector 0 and `op2`=0. Registers 9 and 10 need `op2`=0 and a selector of 0 or 1.
- R4: Register 7 accepts only these (op2, selector) pairs: (0,5), (0,6), (0,7), (1,5), (1,6), (1,10), (4,10), (5,2), (6,5). Register 8 accepts only (0,5), (0,6), (0,7), (1,5), (1,6).
- R5: Register 14 needs `op2`=0 and a selector in {0,3,4,8,9}. Each of these selectors addresses its own 32-bit word. Register 15 needs `op2`=0 and selector 1.
- R6: After reset, these reads return the following values:
  - register 0 with `op2`=0 returns 0x69052000;
  - register 0 with `op2`≠0 returns 0x0B1AA1AA;
  - register 1 with `op2`=0 returns 0x00000078;
  - every other word returns 0.
- R7: A write to register 1 with `op2`=0 stores (data & 0x00003B87) | 0x00000078.
- R8: A write to register 1 with `op2`≠0 stores data & 0x33. This word reads back with any nonzero `op2`.
- R9: The stored value of a write is data masked as follows:
  - register 2: 0xFFFFC000;
  - register 9: 0x1;
  - register 13: 0xFE000000;
  - register 15: 0x3FFF;
  - register 5: 0x6FF;
  - registers 3, 6 and 14 keep all bits.
- R10: Writes to register 0 in either bank are accepted and dropped. Writes to registers 7, 8 and 10 are accepted, change nothing, and those registers read 0.
- R11: `rdData` is 0 on every write, every idle cycle and every rejected access. This includes register 15 with a selector other than 1.
- R12: `endianPulse` is high for exactly the one cycle after an accepted write to register 1 (`op2`=0) whose stored bit 7 differs from the previous value. Otherwise it is 0.
- R13: A rejected access asserts `undefResp` in the same cycle and changes no stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| accValid | input | 1 | Access present this cycle |
| accWrite | input | 1 | 1 = write, 0 = read |
| priReg | input | 4 | Primary register number |
| secSel | input | 4 | Secondary register selector |
| op1 | input | 3 | opcode_1 field |
| op2 | input | 3 | opcode_2 field (nonzero selects alternate bank) |
| userMode | input | 1 | Core is in unprivileged mode |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data, valid with accept on a read |
| accept | output | 1 | Access legal and performed |
| undefResp | output | 1 | Access illegal, undefined-instruction response |
| endianPulse | output | 1 | One-cycle pulse on byte-order bit change |

## Verification
The legality check is exercised with register 7 and register 8 pairs that are legal and with near-miss pairs that differ in only one field. This shows that the pair table is decoded jointly rather than field by field. All-ones writes expose each register's mask and forced-one bits. Zero writes to the control word show that the forced-one bits stay set. Repeated control writes with and without a byte-order change tell a level from an edge on `endianPulse`. Rejected writes from user mode and with a nonzero opcode_1 are followed by reads that show the target word unchanged.

// File: rtl/sysctl_pkg.sv
`timescale 1ns/1ps
package sysctl_pkg;
  localparam int DATA_W = 32;
  localparam int DBG_WORDS = 5;
  localparam int DBG_IDX_W = $clog2(DBG_WORDS);

  localparam logic [DATA_W-1:0] CTRL_MASK  = 32'h0000_3B87;
  localparam logic [DATA_W-1:0] CTRL_FORCE = 32'h0000_0078;
  localparam logic [DATA_W-1:0] AUX_MASK   = 32'h0000_0033;
  localparam logic [DATA_W-1:0] TTB_MASK   = 32'hFFFF_C000;
  localparam logic [DATA_W-1:0] FSR_MASK   = 32'h0000_06FF;
  localparam logic [DATA_W-1:0] DCL_MASK   = 32'h0000_0001;
  localparam logic [DATA_W-1:0] PID_MASK   = 32'hFE00_0000;
  localparam logic [DATA_W-1:0] CAR_MASK   = 32'h0000_3FFF;
  localparam int ENDIAN_BIT = 7;

  typedef struct packed {
    logic                 rdEn;
    logic                 wrEn;
    logic [3:0]           regIdx;
    logic                 altBank;
    logic [DBG_IDX_W-1:0] dbgIdx;
  } ctrlStrobe_t;

  function automatic logic [DBG_IDX_W-1:0] dbgSlot(input logic [3:0] sel);
    case (sel)
      4'd3:    dbgSlot = DBG_IDX_W'(1);
      4'd4:    dbgSlot = DBG_IDX_W'(2);
      4'd8:    dbgSlot = DBG_IDX_W'(3);
      4'd9:    dbgSlot = DBG_IDX_W'(4);
      default: dbgSlot = DBG_IDX_W'(0);
    endcase
  endfunction
endpackage

// File: rtl/sysctl_ctrl.sv
`timescale 1ns/1ps
module sysctl_ctrl
  import sysctl_pkg::*;
(
  input  logic        accValid,
  input  logic        accWrite,
  input  logic [3:0]  priReg,
  input  logic [3:0]  secSel,
  input  logic [2:0]  op1,
  input  logic [2:0]  op2,
  input  logic        userMode,
  output logic        accept,
  output logic        undefResp,
  output ctrlStrobe_t strobe
);
  logic legal;
  logic selZero, op2Zero;

  assign selZero = (secSel == 4'd0);
  assign op2Zero = (op2 == 3'd0);

  always_comb begin
    legal = 1'b0;
    case (priReg)
      4'd0, 4'd1:                   legal = selZero;
      4'd2, 4'd3, 4'd5, 4'd6, 4'd13: legal = selZero && op2Zero;
      4'd7: begin
        case (op2)
          3'd0:    legal = (secSel == 4'd5) || (secSel == 4'd6) || (secSel == 4'd7);
          3'd1:    legal = (secSel == 4'd5) || (secSel == 4'd6) || (secSel == 4'd10);
          3'd4:    legal = (secSel == 4'd10);
          3'd5:    legal = (secSel == 4'd2);
          3'd6:    legal = (secSel == 4'd5);
          default: legal = 1'b0;
        endcase
      end
      4'd8: legal = (op2Zero && secSel >= 4'd5 && secSel <= 4'd7)
                 || (op2 == 3'd1 && (secSel == 4'd5 || secSel == 4'd6));
      4'd9, 4'd10: legal = op2Zero && (secSel <= 4'd1);
      4'd14: legal = op2Zero && (selZero || secSel == 4'd3 || secSel == 4'd4
                                 || secSel == 4'd8 || secSel == 4'd9);
      4'd15: legal = op2Zero && (secSel == 4'd1);
      default: legal = 1'b0;
    endcase
    if (userMode || op1 != 3'd0) legal = 1'b0;
  end

  assign accept    = accValid && legal;
  assign undefResp = accValid && !legal;

  always_comb begin
    strobe.rdEn    = accept && !accWrite;
    strobe.wrEn    = accept && accWrite;
    strobe.regIdx  = priReg;
    strobe.altBank = !op2Zero;
    strobe.dbgIdx  = dbgSlot(secSel);
  end
endmodule

// File: rtl/sysctl_dp.sv
`timescale 1ns/1ps
module sysctl_dp
  import sysctl_pkg::*;
#(
  parameter logic [31:0] ID_VALUE    = 32'h6905_2000,
  parameter logic [31:0] CACHE_VALUE = 32'h0B1A_A1AA
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              endianPulse
);
  logic [DATA_W-1:0] ctrlReg, auxReg, ttbReg, dacReg, fsrReg, farReg;
  logic [DATA_W-1:0] dclReg, pidReg, carReg;
  logic [DATA_W-1:0] dbgReg [DBG_WORDS];
  logic [DATA_W-1:0] ctrlNext;
  logic              wrMain, wrAlt;

  assign wrMain   = strobe.wrEn && !strobe.altBank;
  assign wrAlt    = strobe.wrEn && strobe.altBank;
  assign ctrlNext = (wrData & CTRL_MASK) | CTRL_FORCE;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg     <= CTRL_FORCE;
      auxReg      <= '0;
      ttbReg      <= '0;
      dacReg      <= '0;
      fsrReg      <= '0;
      farReg      <= '0;
      dclReg      <= '0;
      pidReg      <= '0;
      carReg      <= '0;
      endianPulse <= 1'b0;
    end else begin
      endianPulse <= 1'b0;
      if (wrAlt && strobe.regIdx == 4'd1) auxReg <= wrData & AUX_MASK;
      if (wrMain) begin
        case (strobe.regIdx)
          4'd1: begin
            ctrlReg     <= ctrlNext;
            endianPulse <= ctrlNext[ENDIAN_BIT] != ctrlReg[ENDIAN_BIT];
          end
          4'd2:  ttbReg <= wrData & TTB_MASK;
          4'd3:  dacReg <= wrData;
          4'd5:  fsrReg <= wrData & FSR_MASK;
          4'd6:  farReg <= wrData;
          4'd9:  dclReg <= wrData & DCL_MASK;
          4'd13: pidReg <= wrData & PID_MASK;
          4'd15: carReg <= wrData & CAR_MASK;
          default: ;
        endcase
      end
    end
  end

  for (genvar g = 0; g < DBG_WORDS; g++) begin : gDbg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        dbgReg[g] <= '0;
      else if (wrMain && strobe.regIdx == 4'd14 && strobe.dbgIdx == DBG_IDX_W'(g))
        dbgReg[g] <= wrData;
    end
  end

  always_comb begin
    rdData = '0;
    if (strobe.rdEn) begin
      if (strobe.altBank) begin
        case (strobe.regIdx)
          4'd0:    rdData = CACHE_VALUE;
          4'd1:    rdData = auxReg;
          default: rdData = '0;
        endcase
      end else begin
        case (strobe.regIdx)
          4'd0:    rdData = ID_VALUE;
          4'd1:    rdData = ctrlReg;
          4'd2:    rdData = ttbReg;
          4'd3:    rdData = dacReg;
          4'd5:    rdData = fsrReg;
          4'd6:    rdData = farReg;
          4'd9:    rdData = dclReg;
          4'd13:   rdData = pidReg;
          4'd14:   rdData = dbgReg[strobe.dbgIdx];
          4'd15:   rdData = carReg;
          default: rdData = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/sysctl_regfile.sv
`timescale 1ns/1ps
module sysctl_regfile
  import sysctl_pkg::*;
#(
  parameter logic [31:0] ID_VALUE    = 32'h6905_2000,
  parameter logic [31:0] CACHE_VALUE = 32'h0B1A_A1AA
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        accValid,
  input  logic        accWrite,
  input  logic [3:0]  priReg,
  input  logic [3:0]  secSel,
  input  logic [2:0]  op1,
  input  logic [2:0]  op2,
  input  logic        userMode,
  input  logic [31:0] wrData,
  output logic [31:0] rdData,
  output logic        accept,
  output logic        undefResp,
  output logic        endianPulse
);
  ctrlStrobe_t strobe;

  sysctl_ctrl u_ctrl (
    .accValid (accValid),
    .accWrite (accWrite),
    .priReg   (priReg),
    .secSel   (secSel),
    .op1      (op1),
    .op2      (op2),
    .userMode (userMode),
    .accept   (accept),
    .undefResp(undefResp),
    .strobe   (strobe)
  );

  sysctl_dp #(.ID_VALUE(ID_VALUE), .CACHE_VALUE(CACHE_VALUE)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .wrData     (wrData),
    .rdData     (rdData),
    .endianPulse(endianPulse)
  );
endmodule

// File: rtl/sysctl_chk.sv
`timescale 1ns/1ps
module sysctl_chk (
  input logic        clk,
  input logic        rstN,
  input logic        accValid,
  input logic        accWrite,
  input logic [3:0]  priReg,
  input logic [2:0]  op1,
  input logic [2:0]  op2,
  input logic        userMode,
  input logic [31:0] rdData,
  input logic        accept,
  input logic        undefResp,
  input logic        endianPulse
);
  assert_user_reject_R1: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && userMode) |-> (undefResp && !accept));

  assert_op1_reject_R2: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && op1 != 3'd0) |-> undefResp);

  assert_closed_regs_R3: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && (priReg == 4'd4 || priReg == 4'd11 || priReg == 4'd12)) |-> undefResp);

  assert_zero_data_R11: assert property (@(posedge clk) disable iff (!rstN)
    (!accept || accWrite) |-> (rdData == 32'd0));

  assert_pulse_cause_R12: assert property (@(posedge clk) disable iff (!rstN)
    endianPulse |-> $past(accept && accWrite && priReg == 4'd1 && op2 == 3'd0));

  assert_one_response_R13: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({accept, undefResp}) && (accValid == (accept || undefResp)));
endmodule

bind sysctl_regfile sysctl_chk u_chk (.*);

// File: tb/tb_sysctl_regfile.sv
`timescale 1ns/1ps
module tb_sysctl_regfile;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        accValid = 1'b0, accWrite = 1'b0, userMode = 1'b0;
  logic [3:0]  priReg = '0, secSel = '0;
  logic [2:0]  op1 = '0, op2 = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        accept, undefResp, endianPulse;

  int tests = 0;
  int fails = 0;

  typedef struct {
    bit          acc;
    logic [31:0] rd;
    bit          pulse;
    string       tag;
  } exp_t;
  exp_t expQ[$];

  always #2.5 clk = ~clk;

  sysctl_regfile dut (.*);

  task automatic acc(input bit wr, input int r, input int s, input int o1, input int o2,
                     input bit usr, input logic [31:0] d, input bit expAcc,
                     input logic [31:0] expRd, input bit expPulse, input string tag);
    exp_t e;
    accValid = 1'b1; accWrite = wr; priReg = 4'(r); secSel = 4'(s);
    op1 = 3'(o1); op2 = 3'(o2); userMode = usr; wrData = d;
    e.acc = expAcc; e.rd = expRd; e.pulse = expPulse; e.tag = tag;
    expQ.push_back(e);
    @(negedge clk);
  endtask

  task automatic rd(input int r, input int s, input int o2, input bit expAcc,
                    input logic [31:0] expRd, input bit expPulse, input string tag);
    acc(1'b0, r, s, 0, o2, 1'b0, 32'h0, expAcc, expRd, expPulse, tag);
  endtask

  task automatic wr(input int r, input int s, input int o2, input logic [31:0] d,
                    input bit expAcc, input bit expPulse, input string tag);
    acc(1'b1, r, s, 0, o2, 1'b0, d, expAcc, 32'h0, expPulse, tag);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(negedge clk);
      #1;
      if (expQ.size() > 0) begin
        e = expQ.pop_front();
        tests++;
        if (accept !== e.acc || undefResp !== !e.acc || rdData !== e.rd
            || endianPulse !== e.pulse) begin
          fails++;
          $display("FAIL %s: acc=%0b undef=%0b rd=%h pulse=%0b expected acc=%0b undef=%0b rd=%h pulse=%0b",
                   e.tag, accept, undefResp, rdData, endianPulse,
                   e.acc, !e.acc, e.rd, e.pulse);
        end
      end
    end
  end

  task automatic runAll();
    @(negedge clk); @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R6 reset values
    rd(0, 0, 0, 1, 32'h6905_2000, 0, "R6 id");
    rd(0, 0, 1, 1, 32'h0B1A_A1AA, 0, "R6 cache type");
    rd(1, 0, 0, 1, 32'h0000_0078, 0, "R6 control");
    rd(2, 0, 0, 1, 32'h0, 0, "R6 ttb");
    // R1, R2
    acc(0, 1, 0, 0, 0, 1, 0, 0, 0, 0, "R1 user read");
    acc(0, 1, 0, 2, 0, 0, 0, 0, 0, 0, "R2 op1 nonzero");
    // R3
    rd(4, 0, 0, 0, 0, 0, "R3 reg4");
    rd(11, 0, 0, 0, 0, 0, "R3 reg11");
    rd(12, 0, 0, 0, 0, 0, "R3 reg12");
    rd(0, 1, 0, 0, 0, 0, "R3 reg0 sel1");
    rd(1, 0, 3, 1, 0, 0, "R3 reg1 op2=3");
    rd(2, 0, 1, 0, 0, 0, "R3 reg2 op2=1");
    rd(13, 2, 0, 0, 0, 0, "R3 reg13 sel2");
    rd(9, 2, 0, 0, 0, 0, "R3 reg9 sel2");
    // R4
    rd(7, 5, 0, 1, 0, 0, "R4 r7 (0,5)");
    rd(7, 5, 6, 1, 0, 0, "R4 r7 (6,5)");
    rd(7, 2, 5, 1, 0, 0, "R4 r7 (5,2)");
    rd(7, 10, 4, 1, 0, 0, "R4 r7 (4,10)");
    rd(7, 10, 1, 1, 0, 0, "R4 r7 (1,10)");
    rd(7, 5, 2, 0, 0, 0, "R4 r7 (2,5)");
    rd(7, 4, 0, 0, 0, 0, "R4 r7 (0,4)");
    rd(7, 10, 0, 0, 0, 0, "R4 r7 (0,10)");
    rd(8, 7, 1, 0, 0, 0, "R4 r8 (1,7)");
    rd(8, 6, 1, 1, 0, 0, "R4 r8 (1,6)");
    rd(8, 7, 0, 1, 0, 0, "R4 r8 (0,7)");
    rd(8, 5, 2, 0, 0, 0, "R4 r8 (2,5)");
    // R5 debug words
    wr(14, 3, 0, 32'hDEAD_BEEF, 1, 0, "R5 dbg sel3 write");
    wr(14, 9, 0, 32'h1234_5678, 1, 0, "R5 dbg sel9 write");
    rd(14, 3, 0, 1, 32'hDEAD_BEEF, 0, "R5 dbg sel3 read");
    rd(14, 9, 0, 1, 32'h1234_5678, 0, "R5 dbg sel9 read");
    rd(14, 0, 0, 1, 32'h0, 0, "R5 dbg sel0 read");
    rd(14, 5, 0, 0, 0, 0, "R5 dbg sel5 reject");
    rd(14, 3, 1, 0, 0, 0, "R5 dbg op2=1 reject");
    rd(15, 0, 0, 0, 0, 0, "R11 reg15 sel0 reads 0");
    wr(15, 1, 0, 32'hFFFF_FFFF, 1, 0, "R9 car write");
    rd(15, 1, 0, 1, 32'h0000_3FFF, 0, "R9 car mask");
    rd(15, 2, 0, 0, 0, 0, "R11 reg15 sel2 reads 0");
    // R7, R12
    wr(1, 0, 0, 32'hFFFF_FFFF, 1, 0, "R7 ctrl write ones");
    rd(1, 0, 0, 1, 32'h0000_3BFF, 1, "R7 R12 ctrl mask and pulse");
    wr(1, 0, 0, 32'h0, 1, 0, "R7 ctrl write zero");
    rd(1, 0, 0, 1, 32'h0000_0078, 1, "R7 R12 forced ones, pulse");
    wr(1, 0, 0, 32'h0, 1, 0, "R12 ctrl same bit7");
    rd(1, 0, 0, 1, 32'h0000_0078, 0, "R12 no pulse");
    // R8
    wr(1, 0, 2, 32'hFFFF_FFFF, 1, 0, "R8 aux write");
    rd(1, 0, 1, 1, 32'h0000_0033, 0, "R8 aux mask");
    rd(1, 0, 0, 1, 32'h0000_0078, 0, "R8 ctrl untouched by aux");
    // R9
    wr(2, 0, 0, 32'hFFFF_FFFF, 1, 0, "R9 ttb write");
    rd(2, 0, 0, 1, 32'hFFFF_C000, 0, "R9 ttb mask");
    wr(5, 0, 0, 32'hFFFF_FFFF, 1, 0, "R9 fsr write");
    rd(5, 0, 0, 1, 32'h0000_06FF, 0, "R9 fsr mask");
    wr(3, 0, 0, 32'hA5A5_A5A5, 1, 0, "R9 dac write");
    rd(3, 0, 0, 1, 32'hA5A5_A5A5, 0, "R9 dac full");
    wr(6, 0, 0, 32'h1357_9BDF, 1, 0, "R9 far write");
    rd(6, 0, 0, 1, 32'h1357_9BDF, 0, "R9 far full");
    wr(9, 1, 0, 32'hFFFF_FFFF, 1, 0, "R9 dcl write");
    rd(9, 0, 0, 1, 32'h0000_0001, 0, "R9 dcl mask");
    wr(13, 0, 0, 32'hFFFF_FFFF, 1, 0, "R9 pid write");
    rd(13, 0, 0, 1, 32'hFE00_0000, 0, "R9 pid mask");
    // R10
    wr(0, 0, 0, 32'h1, 1, 0, "R10 id write accepted");
    rd(0, 0, 0, 1, 32'h6905_2000, 0, "R10 id unchanged");
    wr(0, 0, 3, 32'h1, 1, 0, "R10 cache write accepted");
    rd(0, 0, 3, 1, 32'h0B1A_A1AA, 0, "R10 cache unchanged");
    wr(10, 0, 0, 32'hFFFF_FFFF, 1, 0, "R10 reg10 write");
    rd(10, 0, 0, 1, 32'h0, 0, "R10 reg10 reads 0");
    wr(7, 5, 0, 32'hFFFF_FFFF, 1, 0, "R10 reg7 write");
    rd(7, 5, 0, 1, 32'h0, 0, "R10 reg7 reads 0");
    // R13
    acc(1, 3, 0, 0, 0, 1, 32'h1, 0, 0, 0, "R13 user write rejected");
    rd(3, 0, 0, 1, 32'hA5A5_A5A5, 0, "R13 dac kept");
    acc(1, 1, 0, 1, 0, 0, 32'hFFFF_FFFF, 0, 0, 0, "R13 op1 ctrl write rejected");
    rd(1, 0, 0, 1, 32'h0000_0078, 0, "R13 ctrl kept, no pulse");
    acc(1, 14, 5, 0, 0, 0, 32'hFFFF_FFFF, 0, 0, 0, "R13 bad dbg write");
    rd(14, 0, 0, 1, 32'h0, 0, "R13 dbg0 kept");
    accValid = 1'b0; accWrite = 1'b0;
    @(negedge clk); @(negedge clk);
  endtask

  initial begin
    fork
      runAll();
      begin
        repeat (200000) @(negedge clk);
        tests++; fails++;
        $display("FAIL watchdog: run did not complete, expected completion");
      end
    join_any
    disable fork;
    if (expQ.size() != 0) begin
      tests++; fails++;
      $display("FAIL scoreboard: %0d items left, expected 0", expQ.size());
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule